// File: doc/BRIEF.md
# Command Header Parity Gate

This block sits behind a serial-peripheral slave's shift logic. At the end of each frame it receives the decoded command header: a register address, a direction bit and a parity bit produced by the master. It checks that parity, opens the register-file write strobe only for a clean write, and always lets a read go ahead. It also keeps a sticky frame-error flag. The register file and the response path both read that flag.

The header is sampled on a one-cycle frame-complete strobe, and every output is registered. For a frame that completes in cycle N, the enables pulse for exactly one cycle in cycle N+1. The error flag takes its new value in the same cycle and then holds until the next strobe. Serial shifting, chip-select handling and storage of registers are done elsewhere.

Top module: `cmd_par_gate`

## Requirements
- R1: A header is clean when the total number of ones over the address bits, the direction bit and the parity bit is odd. A header with an even total is a parity error.
- R2: When a strobed header has direction bit 1 (write) and is clean, `wr_en` is 1 for exactly the one cycle after the strobe.
- R3: When a strobed header has direction bit 1 and a parity error, `wr_en` stays 0.
- R4: When a strobed header has direction bit 0 (read), `rd_en` is 1 for exactly the one cycle after the strobe. This holds whether or not the parity is correct.
- R5: A strobed header with a parity error sets `frame_err` to 1 in the cycle after the strobe, for both directions.
- R6: A strobed clean header clears `frame_err` to 0 in the cycle after the strobe.
- R7: `frame_err` is 0 after reset and changes only in the cycle that follows a strobe. Header inputs presented without a strobe have no effect on any output.
- R8: With address 0 and direction 0, parity 1 is clean and parity 0 is an error. With the address all ones and direction 1, parity 0 is clean and parity 1 is an error.
- R9: `wr_en` and `rd_en` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_done | input | 1 | One-cycle strobe: the header fields are valid |
| hdr_addr | input | ADDR_W | Register address from the header |
| hdr_wr | input | 1 | Direction bit: 1 for write, 0 for read |
| hdr_par | input | 1 | Parity bit sent by the master |
| wr_en | output | 1 | Write strobe to the register file |
| rd_en | output | 1 | Read strobe to the register file |
| frame_err | output | 1 | Sticky frame-error flag for the status and response paths |

## Verification
The bench targets the two extreme headers, where an even/odd mix-up or a parity bit left out of the check gives the wrong verdict. It also targets a bad read, which a design that handled both directions alike would drop. Runs of bad frames followed by one good frame show whether the flag clears only on a clean strobe. Header values toggled without a strobe expose a design that leaks enables or updates the flag between strobes.

// File: rtl/cmd_par_gate_pkg.sv
package cmd_par_gate_pkg;

    typedef enum logic {
        DIR_READ  = 1'b0,
        DIR_WRITE = 1'b1
    } dir_e;

    typedef struct packed {
        logic wr_en;
        logic rd_en;
        logic frame_err;
    } gate_state_t;

    localparam gate_state_t GATE_RESET = '{wr_en: 1'b0, rd_en: 1'b0, frame_err: 1'b0};

endpackage

// File: rtl/cpg_odd_check.sv
module cpg_odd_check #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] bits_in,
    output logic             odd_out
);
    logic [WIDTH-1:0] chain;

    assign chain[0] = bits_in[0];
    for (genvar i = 1; i < WIDTH; i++) begin : g_xor
        assign chain[i] = chain[i-1] ^ bits_in[i];
    end

    assign odd_out = chain[WIDTH-1];
endmodule

// File: rtl/cpg_decide.sv
module cpg_decide
    import cmd_par_gate_pkg::*;
(
    input  logic        strobe,
    input  dir_e        dir,
    input  logic        hdr_clean,
    input  gate_state_t cur,
    output gate_state_t nxt
);
    always_comb begin
        nxt.wr_en     = 1'b0;
        nxt.rd_en     = 1'b0;
        nxt.frame_err = cur.frame_err;
        if (strobe) begin
            nxt.frame_err = ~hdr_clean;
            if (dir == DIR_WRITE) begin
                nxt.wr_en = hdr_clean;
            end else begin
                nxt.rd_en = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cmd_par_gate.sv
module cmd_par_gate
    import cmd_par_gate_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_done,
    input  logic [ADDR_W-1:0] hdr_addr,
    input  logic              hdr_wr,
    input  logic              hdr_par,
    output logic              wr_en,
    output logic              rd_en,
    output logic              frame_err
);
    localparam int HDR_W = ADDR_W + 2;

    logic [HDR_W-1:0] hdr_bits;
    logic             hdr_clean;
    gate_state_t      state_d, state_q;

    assign hdr_bits = {hdr_par, hdr_wr, hdr_addr};

    cpg_odd_check #(.WIDTH(HDR_W)) i_odd (
        .bits_in (hdr_bits),
        .odd_out (hdr_clean)
    );

    cpg_decide i_decide (
        .strobe    (frame_done),
        .dir       (dir_e'(hdr_wr)),
        .hdr_clean (hdr_clean),
        .cur       (state_q),
        .nxt       (state_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GATE_RESET;
        else        state_q <= state_d;
    end

    assign wr_en     = state_q.wr_en;
    assign rd_en     = state_q.rd_en;
    assign frame_err = state_q.frame_err;

    // R3
    bad_write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && hdr_wr && ($countones(hdr_bits) % 2 == 0)) |=> !wr_en);

    // R4
    read_always_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !hdr_wr) |=> rd_en);

    // R5
    err_raised_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && ($countones(hdr_bits) % 2 == 0)) |=> frame_err);

    // R7
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> $stable(frame_err));

    // R7
    no_strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> (!wr_en && !rd_en));

    // R9
    enables_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({wr_en, rd_en}) <= 1);
endmodule

// File: tb/test_cmd_par_gate.sv
module test_cmd_par_gate;
    localparam int  ADDR_W = 6;
    localparam time CLK_P  = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_done = 1'b0;
    logic [ADDR_W-1:0] hdr_addr = '0;
    logic              hdr_wr = 1'b0;
    logic              hdr_par = 1'b0;
    logic              wr_en, rd_en, frame_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit m_wr = 0, m_rd = 0, m_err = 0;

    always #(CLK_P/2) clk = ~clk;

    cmd_par_gate #(.ADDR_W(ADDR_W)) i_cmd_par_gate (
        .clk, .rst_n, .frame_done, .hdr_addr, .hdr_wr, .hdr_par,
        .wr_en, .rd_en, .frame_err
    );

    task automatic cmp(input string req, input logic act, input bit exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Reference: count ones behaviourally, odd total is clean (R1)
    function automatic bit ref_clean(input logic [ADDR_W-1:0] a, input bit w, input bit p);
        int ones = 0;
        for (int i = 0; i < ADDR_W; i++) if (a[i]) ones++;
        if (w) ones++;
        if (p) ones++;
        return (ones % 2) == 1;
    endfunction

    task automatic step(input bit d, input logic [ADDR_W-1:0] a, input bit w, input bit p);
        bit clean;
        @(negedge clk);
        frame_done = d; hdr_addr = a; hdr_wr = w; hdr_par = p;
        clean = ref_clean(a, w, p);
        m_wr = d && w && clean;
        m_rd = d && !w;
        if (d) m_err = !clean;
        @(posedge clk);
        #1;
        cmp(d ? (w ? (clean ? "R2 wr_en" : "R3 wr_en") : "R3 wr_en idle") : "R7 wr_en", wr_en, m_wr);
        cmp(d ? "R4 rd_en" : "R7 rd_en", rd_en, m_rd);
        cmp(d ? (clean ? "R6 frame_err" : "R5 frame_err") : "R7 frame_err", frame_err, m_err);
        cmp("R9 exclusive", wr_en && rd_en, 1'b0);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 3);
        #1;
        cmp("R7 reset frame_err", frame_err, 1'b0);
        cmp("R7 reset wr_en", wr_en, 1'b0);
        cmp("R7 reset rd_en", rd_en, 1'b0);
        @(negedge clk); rst_n = 1'b1;

        // R8 extreme headers
        step(1, '0, 0, 1);   // clean read
        step(1, '0, 0, 0);   // bad read: performed, error set
        step(1, '1, 1, 0);   // clean write clears error
        step(1, '1, 1, 1);   // bad write blocked
        step(0, '0, 0, 0);   // idle holds error
        step(1, '0, 1, 0);   // clean write (one 1... even-> check by model)
        // R7 header changes without strobe
        step(0, 6'h15, 1, 1);
        step(0, 6'h2a, 0, 0);
        // R6 series of bad frames then one good
        step(1, 6'h03, 1, 1);
        step(1, 6'h03, 0, 0);
        step(1, 6'h03, 1, 0);
        step(0, 6'h00, 0, 0);
        // back-to-back strobes with random content
        for (int i = 0; i < 600; i++) begin
            step(($urandom % 3) != 0, 6'($urandom), 1'($urandom), 1'($urandom));
        end
        // asynchronous reset mid-run returns flag to 0
        step(1, '0, 0, 0);
        @(negedge clk); rst_n = 1'b0; frame_done = 1'b0;
        #1;
        m_wr = 0; m_rd = 0; m_err = 0;
        cmp("R7 reset frame_err", frame_err, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        step(1, 6'h3f, 1, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule